// File: doc/BRIEF.md
# Integer ALU with Zero and Overflow Flags

This block is the arithmetic and logic unit of a simple load/store integer pipeline. It is purely combinational. It takes two operands, `a` and `b`, and a 4-bit operation code. It returns a result word, a zero flag and a signed-overflow flag. Operand width is a parameter and defaults to 32 bits.

Addition and subtraction share one carry chain. Subtraction feeds the chain the inverted `b` with a carry-in of 1. Both set-on-less-than operations reuse that same subtraction:
- The signed variant takes the sign of the difference corrected by the subtraction's overflow.
- The unsigned variant takes the absence of a carry out of the top bit.

The comparison answer appears in bit 0 only. To test two operands for equality, the pipeline issues a subtract and reads the zero flag. Shifts, multiply, divide, immediate extension and instruction decode are handled elsewhere.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) gives `result = a + b` modulo 2^W. `overflow` is set when both operands have the same sign and the result's sign differs from it.
- R2: Code 1 (add unsigned) gives the same sum as code 0. `overflow` is always 0.
- R3: Code 2 (subtract) gives `result = a - b` modulo 2^W. `overflow` is set when the operands' signs differ and the result's sign differs from the sign of `a`.
- R4: Code 3 (subtract unsigned) gives the same difference as code 2. `overflow` is always 0.
- R5: The bitwise codes are 4 for AND, 5 for OR, 6 for XOR and 7 for NOR. Each gives the named bitwise function of `a` and `b`, with `overflow` at 0.
- R6: Code 0xA (signed set-less-than) gives a result whose bit 0 is 1 exactly when `a < b` as two's-complement numbers. This holds even when `a - b` overflows. All other result bits are 0 and `overflow` is 0.
- R7: Code 0xB (unsigned set-less-than) gives a result whose bit 0 is 1 exactly when `a < b` as unsigned numbers. All other result bits are 0 and `overflow` is 0.
- R8: `zero` is 1 exactly when every bit of `result` is 0. Under code 2, `zero` is therefore 1 exactly when `a == b`.
- R9: The unused codes are 8, 9 and 0xC to 0xF. Each gives a result of 0 with `overflow` at 0, so `zero` is 1.
- R10: The overflow of codes 0 and 2 is taken from the XOR of the carry into the top bit and the carry out of it. It matches the sign rules of R1 and R3 at the extremes: most positive plus 1, most negative minus 1, and 0 minus the most negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W (32) | First operand |
| b | input | W (32) | Second operand |
| op | input | 4 | Operation code (see R1 to R9) |
| result | output | W (32) | Operation result |
| zero | output | 1 | High when `result` is all zeros |
| overflow | output | 1 | Signed overflow, only for codes 0 and 2 |

## Verification
The block has no registers, so `result`, `zero` and `overflow` are due in the same cycle as the operands and code that produce them, with zero cycles of latency. The bench changes inputs just after a falling clock edge. It samples all three outputs a few nanoseconds later, before the next rising edge. Because of that timing, no check depends on how events are ordered at a clock edge. The expected values come from the bench's own arithmetic on wider and signed values, not from any carry logic.

// File: rtl/int_alu_pkg.sv
// Shared operation codes for the integer ALU.
// Assumes a 4-bit operation code; unlisted codes are treated as unused.
package int_alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
// Shared ripple adder/subtractor.
// With sub high it adds the inverted b plus a carry-in of 1, giving a - b.
// It exposes the carry into the top bit and the carry out of it for the flags.
module int_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_top_in,
    output logic         c_out
);
    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    // Operand conditioning: invert b for subtraction, and seed the carry.
    always_comb begin
        b_eff    = sub ? ~b : b;
        carry[0] = sub;
    end

    // One full-adder cell per bit, chained through the carry.
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic prop;
        logic gen;
        assign prop       = a[i] ^ b_eff[i];
        assign gen        = a[i] & b_eff[i];
        assign sum[i]     = prop ^ carry[i];
        assign carry[i+1] = gen | (prop & carry[i]);
    end

    assign c_top_in = carry[W-1];
    assign c_out    = carry[W];
endmodule

// File: rtl/int_alu_bitwise.sv
// Bitwise unit. sel picks 0 AND, 1 OR, 2 XOR, 3 NOR.
// Assumes sel comes from the low two bits of the operation code.
module int_alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/int_alu_less.sv
// Less-than decision from a completed subtraction a - b.
// Signed: the sign of the difference corrected by the raw overflow.
// Unsigned: no carry out of the top bit, meaning a borrow occurred.
module int_alu_less (
    input  logic diff_sign,
    input  logic ovf_raw,
    input  logic c_out,
    input  logic is_signed,
    output logic less
);
    // Pick the comparison rule.
    always_comb begin
        less = is_signed ? (diff_sign ^ ovf_raw) : ~c_out;
    end
endmodule

// File: rtl/int_alu.sv
// Combinational integer ALU: add and subtract (signed and unsigned), bitwise
// logic, and set-less-than, with zero and signed-overflow flags.
// Assumes the operands are already extended to W bits.
// Overflow is reported only for the signed add and subtract.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    result,
    output logic            zero,
    output logic            overflow
);
    localparam int MSB = W - 1;

    logic [W-1:0] sum;
    logic [W-1:0] logic_y;
    logic         c_top_in;
    logic         c_out;
    logic         ovf_raw;
    logic         less;
    logic         sub;
    logic         is_signed_cmp;
    logic         signed_arith;

    // Decode: which codes drive the chain as a subtractor, and which report overflow.
    always_comb begin
        sub           = (op == OP_SUB) || (op == OP_SUBU) ||
                        (op == OP_SLT) || (op == OP_SLTU);
        is_signed_cmp = (op == OP_SLT);
        signed_arith  = (op == OP_ADD) || (op == OP_SUB);
    end

    int_alu_addsub #(.W(W)) u_addsub (
        .a        (a),
        .b        (b),
        .sub      (sub),
        .sum      (sum),
        .c_top_in (c_top_in),
        .c_out    (c_out)
    );

    int_alu_bitwise #(.W(W)) u_bitwise (
        .a   (a),
        .b   (b),
        .sel (op[1:0]),
        .y   (logic_y)
    );

    assign ovf_raw = c_top_in ^ c_out;

    int_alu_less u_less (
        .diff_sign (sum[MSB]),
        .ovf_raw   (ovf_raw),
        .c_out     (c_out),
        .is_signed (is_signed_cmp),
        .less      (less)
    );

    // Result select; unused codes give zero.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result = logic_y;
            OP_SLT, OP_SLTU:                  result = {{(W-1){1'b0}}, less};
            default:                          result = '0;
        endcase
    end

    // Flags: zero detect across the result, and gated signed overflow.
    always_comb begin
        zero     = ~|result;
        overflow = ovf_raw & signed_arith;
    end
endmodule

// File: rtl/int_alu_checker.sv
// Assertion checker for int_alu, attached with bind.
// The block is combinational, so the checks are immediate assertions.
// They are skipped while any input is unknown.
module int_alu_checker #(
    parameter int W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [3:0]   op,
    input logic [W-1:0] result,
    input logic         zero,
    input logic         overflow
);
    // Check flag and result relations whenever the inputs are known.
    always_comb begin
        if (!$isunknown({a, b, op})) begin
            p_zero_flag_r8: assert (zero == (result == '0));
            p_no_overflow_r2: assert (!(op == 4'h1 && overflow));
            p_no_overflow_r4: assert (!(op == 4'h3 && overflow));
            p_logic_no_ovf_r5: assert (!(op[3:2] == 2'b01 && overflow));
            p_slt_upper_r6: assert (!(op == 4'hA && result[W-1:1] != '0));
            p_sltu_upper_r7: assert (!(op == 4'hB && result[W-1:1] != '0));
            p_unused_r9: assert (!((op == 4'h8 || op == 4'h9 || op >= 4'hC) &&
                                   (result != '0 || overflow)));
            p_add_ovf_r10: assert (!(op == 4'h0) ||
                overflow == ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1])));
        end
    end
endmodule

bind int_alu int_alu_checker #(.W(W)) u_chk (
    .a        (a),
    .b        (b),
    .op       (op),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
);

// File: tb/int_alu_bench.sv
// Directed bench for int_alu; one task per scenario, each task checks its own results.
module int_alu_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   op = 4'h0;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    // 100 MHz clock.
    always #5 clk = ~clk;

    int_alu #(.W(W)) u_int_alu (
        .a(a), .b(b), .op(op), .result(result), .zero(zero), .overflow(overflow)
    );

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%h a=%h b=%h got=%h exp=%h", tag, op, a, b, got, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] c);
        case (c)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h2: return "R3";
            4'h3: return "R4";
            4'h4, 4'h5, 4'h6, 4'h7: return "R5";
            4'hA: return "R6";
            4'hB: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Apply one operation and check result, overflow and zero against the bench model.
    task automatic run(logic [3:0] c, logic [W-1:0] x, logic [W-1:0] y);
        logic [W-1:0] er;
        logic         eo;
        @(negedge clk);
        op = c; a = x; b = y;
        case (c)
            4'h0, 4'h1: er = x + y;
            4'h2, 4'h3: er = x - y;
            4'h4: er = x & y;
            4'h5: er = x | y;
            4'h6: er = x ^ y;
            4'h7: er = ~(x | y);
            4'hA: er = ($signed(x) < $signed(y)) ? W'(1) : W'(0);
            4'hB: er = (x < y) ? W'(1) : W'(0);
            default: er = '0;
        endcase
        if (c == 4'h0)      eo = (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
        else if (c == 4'h2) eo = (x[W-1] != y[W-1]) && (er[W-1] != x[W-1]);
        else                eo = 1'b0;
        #2;
        check(tag_of(c), result, er);
        check((c == 4'h0 || c == 4'h2) ? "R10" : tag_of(c), W'(overflow), W'(eo));
        check("R8", W'(zero), W'(er == '0));
    endtask

    task automatic t_reset;
        @(negedge clk);
        #2;
        check("R8", W'(zero), W'(1));   // inputs all zero, add gives zero
        check("R1", result, '0);
    endtask

    task automatic t_add;
        run(4'h0, 32'd5, 32'd7);
        run(4'h0, 32'h7FFF_FFFF, 32'd1);     // R10 positive overflow
        run(4'h0, 32'h8000_0000, 32'h8000_0000);
        run(4'h0, 32'hFFFF_FFFF, 32'd1);     // wraps to zero, no signed overflow
        run(4'h1, 32'h7FFF_FFFF, 32'd1);     // R2 overflow suppressed
        run(4'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_sub;
        run(4'h2, 32'd9, 32'd9);             // R8 equality via subtract
        run(4'h2, 32'd3, 32'd10);
        run(4'h2, 32'h8000_0000, 32'd1);     // R10 most negative minus one
        run(4'h2, 32'd0, 32'h8000_0000);     // R10 zero minus most negative
        run(4'h3, 32'h8000_0000, 32'd1);     // R4 suppressed
        run(4'h3, 32'd0, 32'd1);
    endtask

    task automatic t_logic;
        for (int c = 4; c < 8; c++) begin
            run(4'(c), 32'h0000_3C00, 32'h0000_0D00);
            run(4'(c), 32'hFFFF_0000, 32'h0F0F_F0F0);
        end
        run(4'h4, 32'hAAAA_AAAA, 32'h5555_5555);   // zero result from AND
    endtask

    task automatic t_slt;
        run(4'hA, 32'hFFFF_FFFF, 32'd1);     // R6 -1 < 1
        run(4'hA, 32'd1, 32'hFFFF_FFFF);
        run(4'hA, 32'h8000_0000, 32'h7FFF_FFFF); // R6 overflowing subtraction
        run(4'hA, 32'h7FFF_FFFF, 32'h8000_0000);
        run(4'hA, 32'd4, 32'd4);
        run(4'hB, 32'hFFFF_FFFF, 32'd1);     // R7 unsigned: large not less
        run(4'hB, 32'd1, 32'hFFFF_FFFF);
        run(4'hB, 32'd0, 32'd0);
        run(4'hB, 32'h7FFF_FFFF, 32'h8000_0000);
    endtask

    task automatic t_unused;
        for (int c = 8; c < 16; c++) begin
            if (c != 10 && c != 11) run(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF); // R9
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Test sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_slt();
        t_unused();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule